// File: doc/BRIEF.md
# SPI Host Controller with Select Guard

This block is an SPI host (master) for full-duplex byte transfers, driven through three byte-wide registers on a simple strobe bus. Software sets a divide code, the clock polarity and the clock phase, and then turns on the host and enable bits. Each accepted write to the data register sends one word out on MOSI, most significant bit first, while the same number of bits is taken in from MISO. When the word is done, a completion flag rises, and an interrupt follows it if software has allowed that.

A guard input decides whether host operation is allowed. The internal select comes either from a synchronized external pin or from a software bit, and a mode bit chooses between the two. While the chosen select is low, hardware holds the host and enable bits at zero, and any transfer in progress is dropped. The completion flag has a two-step clear: software must first touch the status register and then read the data register.

Register map (2-bit address): 0 = control, 1 = status, 2 = data. Control bits: [0] interrupt enable, [1] host, [2] enable, [3] CPOL, [4] CPHA, [7:5] divide code. Status bits: [0] software select value, [1] software select mode, [7] completion flag (read-only), all other bits read zero.

Top module: `spi_host_ctl`

## Requirements
- R1: A transfer moves 8 bits. MOSI presents the byte written to the data register (address 2), most significant bit first, and exactly 16 SCK edges are produced.
- R2: A write to the data register starts a transfer only when control bits [1] and [2] are both 1 and no transfer is running. Any other such write has no effect: SCK does not toggle and the data register keeps its previous contents.
- R3: When no transfer is running, SCK sits at the CPOL value (control bit 3).
- R4: With CPHA (control bit 4) = 0, MISO is sampled on the first, third, ... SCK edges and MOSI changes on the others. With CPHA = 1 this is reversed. After completion, the received word reads back from the data register, first received bit in bit 7.
- R5: The divide code (control bits [7:5]) sets the SCK half period to 2^(1+c) system clocks for c in 0..6, and code 7 behaves as code 6. The first SCK edge comes one half period after the clock edge that takes the data write.
- R6: The completion flag (status bit 7) becomes 1 one system clock after the final SCK edge.
- R7: The interrupt output is high exactly while the completion flag is 1 and control bit 0 is 1.
- R8: The completion flag clears only when a data register read follows a status register access (read or write) made while the flag was set. A data read without that earlier access leaves the flag set.
- R9: When status bit 1 is 1, the internal select follows status bit 0. When status bit 1 is 0, it follows the external select pin after SYNC_STAGES clocks of synchronization.
- R10: While the internal select is low, control bits [1] and [2] are forced to 0 on the next clock, and writes cannot set them. All other control bits are unaffected.
- R11: If host or enable drops during a transfer, the transfer is abandoned: SCK returns to its idle level and the completion flag does not rise.
- R12: A data register write made while a transfer is running is ignored, and the word being sent is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register address (0 control, 1 status, 2 data) |
| reg_wr | input | 1 | Write strobe, one clock per access |
| reg_rd | input | 1 | Read strobe, one clock per access; reads have side effects |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| sel_pin | input | 1 | External select guard input, active high permits host mode |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Completion interrupt request |

## Verification
Let h be the half period, where h = 2^(1+c). A data write that the bus presents at clock edge t0 gives SCK edges at t0 + k*h for k = 1..16, and the completion flag and interrupt follow one clock after edge 16. The select pin clears the host bits SYNC_STAGES+1 clocks after it falls, and a bus access takes effect on the edge during which its strobe is high. The bench drives every input and samples every output on the falling clock edge, counting falling edges from the write to predict each SCK edge, the half period and the flag edge. It checks the interrupt both one sample before and one sample after the flag is due, and it allows several clocks of margin before observing the select-driven clears.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

   localparam int BUS_W  = 8;
   localparam int RATE_W = 3;

   localparam logic [1:0] ADDR_CTL  = 2'd0;
   localparam logic [1:0] ADDR_STAT = 2'd1;
   localparam logic [1:0] ADDR_DATA = 2'd2;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_TAIL = 2'd2
   } xfer_state_t;

   typedef struct packed {
      logic [RATE_W-1:0] rate;
      logic              cpha;
      logic              cpol;
      logic              enable;
      logic              host;
      logic              irq_en;
   } ctl_t;

endpackage

// File: rtl/spi_host_clkgen.sv
module spi_host_clkgen
   import spi_host_pkg::*;
#(
   parameter int MIN_DIV_LOG2 = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [RATE_W-1:0] rate,
   output logic              tick
);

   localparam int MAX_CODE = (1 << RATE_W) - 2;
   localparam int CNT_W    = MIN_DIV_LOG2 + MAX_CODE - 1;
   localparam logic [RATE_W-1:0] MAX_CODE_V = RATE_W'(MAX_CODE);

   if (MIN_DIV_LOG2 < 1) begin : g_bad_div
      $error("MIN_DIV_LOG2 must be at least 1");
   end

   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  limit;
   logic [RATE_W-1:0] code_eff;
   int                shamt;

   always_comb begin
      code_eff = (rate > MAX_CODE_V) ? MAX_CODE_V : rate;
      shamt    = MIN_DIV_LOG2 - 1 + int'(code_eff);
      limit    = CNT_W'((32'd1 << shamt) - 32'd1);
   end

   assign tick = run && (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/spi_host_shifter.sv
module spi_host_shifter
   import spi_host_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int MIN_DIV_LOG2 = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] load_data,
   input  logic              cfg_cpol,
   input  logic              cfg_cpha,
   input  logic [RATE_W-1:0] cfg_rate,
   input  logic              live_ok,
   input  logic              miso,
   output logic              sck,
   output logic              mosi,
   output logic              busy,
   output logic              done_pulse,
   output logic [DATA_W-1:0] rx_data
);

   localparam int EDGES = 2 * DATA_W;
   localparam int EW    = $clog2(EDGES);
   localparam logic [EW-1:0] LAST_IDX = EW'(EDGES - 1);

   xfer_state_t       state_q;
   logic [EW-1:0]     edge_q;
   logic              sck_q;
   logic              rx_bit_q;
   logic [DATA_W-1:0] shreg_q;
   logic              lat_cpol_q;
   logic              lat_cpha_q;
   logic [RATE_W-1:0] lat_rate_q;

   logic tick;
   logic run;
   logic leading;
   logic sample_edge;
   logic last_edge;
   logic shift_edge;

   assign run         = (state_q == ST_RUN) && live_ok;
   assign leading     = ~edge_q[0];
   assign sample_edge = lat_cpha_q ? !leading : leading;
   assign last_edge   = (edge_q == LAST_IDX);
   assign shift_edge  = !sample_edge && !last_edge
                        && !(lat_cpha_q && (edge_q == '0));

   spi_host_clkgen #(
      .MIN_DIV_LOG2(MIN_DIV_LOG2)
   ) clkgen_i (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .rate (lat_rate_q),
      .tick (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         edge_q     <= '0;
         sck_q      <= 1'b0;
         rx_bit_q   <= 1'b0;
         shreg_q    <= '0;
         lat_cpol_q <= 1'b0;
         lat_cpha_q <= 1'b0;
         lat_rate_q <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q    <= ST_RUN;
                  shreg_q    <= load_data;
                  edge_q     <= '0;
                  sck_q      <= cfg_cpol;
                  lat_cpol_q <= cfg_cpol;
                  lat_cpha_q <= cfg_cpha;
                  lat_rate_q <= cfg_rate;
               end
            end
            ST_RUN: begin
               if (!live_ok) begin
                  state_q <= ST_IDLE;
                  sck_q   <= lat_cpol_q;
               end else if (tick) begin
                  sck_q <= ~sck_q;
                  if (sample_edge) begin
                     rx_bit_q <= miso;
                  end
                  if (shift_edge) begin
                     shreg_q <= {shreg_q[DATA_W-2:0], rx_bit_q};
                  end
                  if (last_edge) begin
                     state_q <= ST_TAIL;
                  end else begin
                     edge_q <= edge_q + 1'b1;
                  end
               end
            end
            ST_TAIL: begin
               shreg_q <= {shreg_q[DATA_W-2:0], rx_bit_q};
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign sck        = (state_q == ST_RUN) ? sck_q : cfg_cpol;
   assign mosi       = shreg_q[DATA_W-1];
   assign busy       = (state_q != ST_IDLE);
   assign done_pulse = (state_q == ST_TAIL);
   assign rx_data    = shreg_q;

endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
   import spi_host_pkg::*;
#(
   parameter int DATA_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic              sel_int,
   input  logic              busy,
   input  logic              done_pulse,
   input  logic [DATA_W-1:0] rx_data,
   output ctl_t              ctl,
   output logic              sw_sel_en,
   output logic              sw_sel_val,
   output logic              flag,
   output logic              armed,
   output logic              start,
   output logic              data_rd,
   output logic              irq
);

   ctl_t ctl_q;
   logic sel_en_q;
   logic sel_val_q;
   logic flag_q;
   logic armed_q;
   logic stat_acc;

   assign stat_acc = (bus_wr || bus_rd) && (bus_addr == ADDR_STAT);
   assign data_rd  = bus_rd && (bus_addr == ADDR_DATA);
   assign start    = bus_wr && (bus_addr == ADDR_DATA)
                     && ctl_q.host && ctl_q.enable && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q     <= '0;
         sel_en_q  <= 1'b0;
         sel_val_q <= 1'b0;
      end else begin
         if (bus_wr && (bus_addr == ADDR_CTL)) begin
            ctl_q <= ctl_t'(bus_wdata);
         end
         if (!sel_int) begin
            ctl_q.host   <= 1'b0;
            ctl_q.enable <= 1'b0;
         end
         if (bus_wr && (bus_addr == ADDR_STAT)) begin
            sel_en_q  <= bus_wdata[1];
            sel_val_q <= bus_wdata[0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q  <= 1'b0;
         armed_q <= 1'b0;
      end else if (done_pulse) begin
         flag_q  <= 1'b1;
         armed_q <= 1'b0;
      end else if (flag_q && armed_q && data_rd) begin
         flag_q  <= 1'b0;
         armed_q <= 1'b0;
      end else if (flag_q && stat_acc) begin
         armed_q <= 1'b1;
      end
   end

   always_comb begin
      unique case (bus_addr)
         ADDR_CTL:  bus_rdata = BUS_W'(ctl_q);
         ADDR_STAT: bus_rdata = {flag_q, 5'b0, sel_en_q, sel_val_q};
         ADDR_DATA: bus_rdata = BUS_W'(rx_data);
         default:   bus_rdata = '0;
      endcase
   end

   assign ctl        = ctl_q;
   assign sw_sel_en  = sel_en_q;
   assign sw_sel_val = sel_val_q;
   assign flag       = flag_q;
   assign armed      = armed_q;
   assign irq        = flag_q && ctl_q.irq_en;

endmodule

// File: rtl/spi_host_ctl.sv
module spi_host_ctl
   import spi_host_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int MIN_DIV_LOG2 = 2,
   parameter int SYNC_STAGES  = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [BUS_W-1:0]  reg_wdata,
   output logic [BUS_W-1:0]  reg_rdata,
   input  logic              sel_pin,
   output logic              sck,
   output logic              mosi,
   input  logic              miso,
   output logic              irq
);

   if (DATA_W < 2 || DATA_W > BUS_W) begin : g_bad_width
      $error("DATA_W must lie between 2 and the bus width");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must lie between 0 and 4");
   end

   ctl_t              ctl;
   logic              sw_sel_en;
   logic              sw_sel_val;
   logic              sel_pin_s;
   logic              sel_int;
   logic              flag;
   logic              armed;
   logic              start;
   logic              data_rd;
   logic              busy;
   logic              done_pulse;
   logic [DATA_W-1:0] rx_data;
   logic              cfg_cpol;
   logic              host_en;
   logic              live_ok;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign sel_pin_s = sel_pin;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q <= '1;
         end else begin
            chain_q[0] <= sel_pin;
            for (int i = 1; i < SYNC_STAGES; i++) begin
               chain_q[i] <= chain_q[i-1];
            end
         end
      end
      assign sel_pin_s = chain_q[SYNC_STAGES-1];
   end

   assign sel_int  = sw_sel_en ? sw_sel_val : sel_pin_s;
   assign cfg_cpol = ctl.cpol;
   assign host_en  = ctl.host;
   assign live_ok  = ctl.host && ctl.enable;

   spi_host_regs #(
      .DATA_W(DATA_W)
   ) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (reg_addr),
      .bus_wr    (reg_wr),
      .bus_rd    (reg_rd),
      .bus_wdata (reg_wdata),
      .bus_rdata (reg_rdata),
      .sel_int   (sel_int),
      .busy      (busy),
      .done_pulse(done_pulse),
      .rx_data   (rx_data),
      .ctl       (ctl),
      .sw_sel_en (sw_sel_en),
      .sw_sel_val(sw_sel_val),
      .flag      (flag),
      .armed     (armed),
      .start     (start),
      .data_rd   (data_rd),
      .irq       (irq)
   );

   spi_host_shifter #(
      .DATA_W      (DATA_W),
      .MIN_DIV_LOG2(MIN_DIV_LOG2)
   ) shifter_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .load_data (reg_wdata[DATA_W-1:0]),
      .cfg_cpol  (ctl.cpol),
      .cfg_cpha  (ctl.cpha),
      .cfg_rate  (ctl.rate),
      .live_ok   (live_ok),
      .miso      (miso),
      .sck       (sck),
      .mosi      (mosi),
      .busy      (busy),
      .done_pulse(done_pulse),
      .rx_data   (rx_data)
   );

endmodule

// File: rtl/spi_host_chk.sv
module spi_host_chk (
   input logic clk,
   input logic rst_n,
   input logic sck,
   input logic cfg_cpol,
   input logic busy,
   input logic start,
   input logic done_pulse,
   input logic flag,
   input logic armed,
   input logic data_rd,
   input logic sel_int,
   input logic host_en,
   input logic live_ok,
   input logic irq
);

   assert_sck_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sck == cfg_cpol));

   assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);

   assert_flag_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |=> flag);

   assert_flag_rise_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(done_pulse));

   assert_flag_clear_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag) |-> ($past(armed) && $past(data_rd)));

   assert_sel_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_int |=> (!host_en && !live_ok));

   assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> flag);

endmodule

bind spi_host_ctl spi_host_chk chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .sck       (sck),
   .cfg_cpol  (cfg_cpol),
   .busy      (busy),
   .start     (start),
   .done_pulse(done_pulse),
   .flag      (flag),
   .armed     (armed),
   .data_rd   (data_rd),
   .sel_int   (sel_int),
   .host_en   (host_en),
   .live_ok   (live_ok),
   .irq       (irq)
);

// File: tb/spi_host_ctl_tb_top.sv
module spi_host_ctl_tb_top;

   localparam int CLK_P = 10;
   localparam logic [1:0] A_CTL  = 2'd0;
   localparam logic [1:0] A_STAT = 2'd1;
   localparam logic [1:0] A_DATA = 2'd2;

   // {irq_en, cpol, cpha, rate[2:0], host byte, slave byte}
   localparam int NVEC = 8;
   localparam logic [21:0] VEC [NVEC] = '{
      {1'b1, 1'b0, 1'b0, 3'd0, 8'hA5, 8'h3C},
      {1'b1, 1'b0, 1'b1, 3'd0, 8'h81, 8'h7E},
      {1'b1, 1'b1, 1'b0, 3'd1, 8'hC3, 8'h5A},
      {1'b1, 1'b1, 1'b1, 3'd0, 8'h0F, 8'hF0},
      {1'b0, 1'b0, 1'b0, 3'd2, 8'h96, 8'h69},
      {1'b1, 1'b1, 1'b1, 3'd1, 8'h01, 8'h80},
      {1'b1, 1'b0, 1'b1, 3'd7, 8'hE7, 8'h18},
      {1'b1, 1'b1, 1'b0, 3'd3, 8'hFF, 8'h00}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic       reg_wr = 1'b0;
   logic       reg_rd = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       sel_pin = 1'b1;
   logic       sck;
   logic       mosi;
   logic       miso = 1'b0;
   logic       irq;

   int checks = 0;
   int errors = 0;
   bit summary_done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   spi_host_ctl dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_addr (reg_addr),
      .reg_wr   (reg_wr),
      .reg_rd   (reg_rd),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .sel_pin  (sel_pin),
      .sck      (sck),
      .mosi     (mosi),
      .miso     (miso),
      .irq      (irq)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      if (!summary_done) begin
         summary_done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      reg_rd   = 1'b1;
      #1;
      d = reg_rdata;
      @(negedge clk);
      reg_rd   = 1'b0;
   endtask

   task automatic run_xfer(input bit cpol, input bit cpha, input logic [2:0] rate,
                           input logic [7:0] mtx, input logic [7:0] stx,
                           input bit irqen, input bit mid_wr, input int abort_k,
                           input bit leave_set);
      logic [7:0] srx;
      logic [7:0] rv;
      int k;
      int cyc;
      int last_cyc;
      int h;
      int extra;
      bit prev;
      srx = 8'h00;
      k = 0;
      cyc = 0;
      last_cyc = 0;
      h = 1 << (1 + ((rate == 3'd7) ? 6 : int'(rate)));
      wr(A_CTL, {rate, cpha, cpol, 1'b1, 1'b1, irqen});
      chk(sck === cpol, "R3", "idle sck before start", int'(sck), int'(cpol));
      miso = cpha ? 1'b0 : stx[7];
      prev = sck;
      wr(A_DATA, mtx);
      while (k < 16 && cyc < 4000) begin
         @(negedge clk);
         cyc++;
         reg_wr = 1'b0;
         if (sck !== prev) begin
            k++;
            prev = sck;
            if (k == 1) chk(cyc == h, "R5", "first edge delay", cyc, h);
            if (k == 2) chk(cyc - last_cyc == h, "R5", "half period", cyc - last_cyc, h);
            last_cyc = cyc;
            if (k % 2 == 1) begin
               if (cpha) miso = stx[7 - (k - 1) / 2];
               else      srx  = {srx[6:0], mosi};
            end else begin
               if (cpha)        srx  = {srx[6:0], mosi};
               else if (k < 16) miso = stx[7 - k / 2];
            end
            if (mid_wr && k == 4) begin
               reg_addr  = A_DATA;
               reg_wdata = ~mtx;
               reg_wr    = 1'b1;
            end
            if (abort_k != 0 && k == abort_k) begin
               sel_pin = 1'b0;
               break;
            end
         end
      end
      if (abort_k != 0) begin
         extra = 0;
         prev = sck;
         for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (sck !== prev) begin
               extra++;
               prev = sck;
            end
         end
         chk(sck === cpol, "R11", "sck idle after abort", int'(sck), int'(cpol));
         chk(extra <= 1, "R11", "edges after abort", extra, 1);
         chk(irq === 1'b0, "R11", "irq after abort", int'(irq), 0);
         rd(A_STAT, rv);
         chk(rv[7] === 1'b0, "R11", "flag after abort", int'(rv[7]), 0);
         sel_pin = 1'b1;
         repeat (4) @(negedge clk);
         return;
      end
      chk(k == 16, "R1", "edge count", k, 16);
      chk(irq === 1'b0, "R6", "irq at final edge", int'(irq), 0);
      @(negedge clk);
      if (irqen) chk(irq === 1'b1, "R6", "irq one clock after final edge", int'(irq), 1);
      else       chk(irq === 1'b0, "R7", "irq masked", int'(irq), 0);
      chk(srx == mtx, mid_wr ? "R12" : "R1", "slave received", int'(srx), int'(mtx));
      rd(A_DATA, rv);
      chk(rv == stx, "R4", "received word", int'(rv), int'(stx));
      if (irqen) begin
         chk(irq === 1'b1, "R8", "flag kept after bare data read", int'(irq), 1);
         if (leave_set) return;
         rd(A_STAT, rv);
         chk(rv[7] === 1'b1, "R6", "status flag", int'(rv[7]), 1);
         rd(A_DATA, rv);
         chk(irq === 1'b0, "R8", "flag cleared by sequence", int'(irq), 0);
      end else begin
         rd(A_STAT, rv);
         chk(rv[7] === 1'b1, "R7", "flag set with irq masked", int'(rv[7]), 1);
         chk(irq === 1'b0, "R7", "irq stays low", int'(irq), 0);
         rd(A_DATA, rv);
         rd(A_STAT, rv);
         chk(rv[7] === 1'b0, "R8", "flag cleared", int'(rv[7]), 0);
      end
   endtask

   initial begin
      #(CLK_P * 150000);
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      logic [7:0] rv;
      int edges;
      bit prev;

      // reset state
      repeat (3) @(negedge clk);
      chk(sck === 1'b0, "R3", "sck in reset", int'(sck), 0);
      chk(irq === 1'b0, "R7", "irq in reset", int'(irq), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      rd(A_CTL, rv);
      chk(rv == 8'h00, "R10", "control after reset", int'(rv), 0);
      rd(A_STAT, rv);
      chk(rv == 8'h00, "R8", "status after reset", int'(rv), 0);

      // data write while disabled is ignored
      wr(A_DATA, 8'hA5);
      edges = 0;
      prev = sck;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (sck !== prev) begin
            edges++;
            prev = sck;
         end
      end
      chk(edges == 0, "R2", "no sck when disabled", edges, 0);
      rd(A_DATA, rv);
      chk(rv == 8'h00, "R2", "data not loaded when disabled", int'(rv), 0);
      rd(A_STAT, rv);
      chk(rv[7] === 1'b0, "R2", "no flag when disabled", int'(rv[7]), 0);

      // table of vectors
      for (int v = 0; v < NVEC; v++) begin
         run_xfer(VEC[v][20], VEC[v][19], VEC[v][18:16], VEC[v][15:8], VEC[v][7:0],
                  VEC[v][21], 1'b0, 0, 1'b0);
      end

      // write during transfer ignored
      run_xfer(1'b0, 1'b0, 3'd2, 8'h5A, 8'hC6, 1'b1, 1'b1, 0, 1'b0);

      // status write counts as the first step of the clear
      run_xfer(1'b1, 1'b0, 3'd0, 8'h33, 8'h99, 1'b1, 1'b0, 0, 1'b1);
      wr(A_STAT, 8'h00);
      chk(irq === 1'b1, "R8", "flag held after status write only", int'(irq), 1);
      rd(A_DATA, rv);
      chk(irq === 1'b0, "R8", "cleared after status write then data read", int'(irq), 0);

      // select guard from the pin
      wr(A_CTL, 8'h07);
      rd(A_CTL, rv);
      chk(rv == 8'h07, "R10", "bits set while select high", int'(rv), 8'h07);
      sel_pin = 1'b0;
      repeat (5) @(negedge clk);
      rd(A_CTL, rv);
      chk(rv == 8'h01, "R10", "bits dropped by pin", int'(rv), 8'h01);
      wr(A_CTL, 8'h07);
      rd(A_CTL, rv);
      chk(rv == 8'h01, "R10", "write cannot set bits while low", int'(rv), 8'h01);

      // software select mode
      sel_pin = 1'b1;
      repeat (4) @(negedge clk);
      wr(A_STAT, 8'h03);
      sel_pin = 1'b0;
      wr(A_CTL, 8'h07);
      repeat (5) @(negedge clk);
      rd(A_CTL, rv);
      chk(rv == 8'h07, "R9", "pin ignored in software mode", int'(rv), 8'h07);
      wr(A_STAT, 8'h02);
      repeat (2) @(negedge clk);
      rd(A_CTL, rv);
      chk(rv == 8'h01, "R9", "software select low drops bits", int'(rv), 8'h01);
      sel_pin = 1'b1;
      wr(A_STAT, 8'h00);
      repeat (4) @(negedge clk);

      // abort mid-transfer
      run_xfer(1'b1, 1'b1, 3'd2, 8'hAA, 8'h55, 1'b1, 1'b0, 3, 1'b0);

      summary();
      $finish;
   end

endmodule